// File: doc/BRIEF.md
# Guarded Configuration Register Bank

This block holds five 8-bit system configuration registers behind a plain synchronous bus. A write strobe, an address and a data byte go in, and a read data byte comes out. Each register applies its own write rules bit by bit. Some fields accept writes at any time. Some accept only the first write. Some accept that first write only while a short window after reset is still open. The protection register lets bits be set at any time, but it lets them be cleared only by that single early write. The block does not use the values it stores. Other logic in the chip reads them.

A down-stream boot routine writes the protected fields early, before the window closes, and those fields are then frozen until the next reset. A special-mode input, driven by test or boot logic, turns off every timing and once-only rule while it is high. This lets each implemented bit be written freely. The block checks that input afresh on every clock and never stores it.

Top module: `cfg_guard_bank`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge), every register reads 0x00, except the protection register at address 0x35, which reads 0xFF. All once-only locks are clear.
- R2: A cycle counter starts at 0 on the first rising edge after reset is released and stops at 64. A write is inside the window when fewer than 64 rising edges with rst_n high have passed before the edge that takes it. Edges 0 to 63 are inside and edge 64 and later are outside.
- R3: In the register at 0x24, bits [7:2] take every write. Bits [1:0] take only the first write, and only inside the window.
- R4: In the register at 0x35, the first write inside the window stores the written byte exactly. Any later write, or any write outside the window, can only set bits: stored = old OR data.
- R5: In the register at 0x37, bits [7:4] take only the first write, at any time. Bits [3:0] always read 0.
- R6: In the register at 0x39, bits [7:6] and bit 3 take every write. Bits [5:4] and [2:0] take only the first write, and only inside the window.
- R7: All eight bits of the register at 0x3D take only the first write, and only inside the window.
- R8: Each register has its own lock. The lock is set by the first accepted write of its limited bits in normal mode, even when the written value equals the stored value. Only reset clears it.
- R9: While special_i is 1, a write to any of the five registers stores the written byte on all implemented bits. Locks and the window do not matter, and the write sets no lock.
- R10: A write, or part of a write, that the rules refuse leaves the affected stored bits unchanged and reports nothing.
- R11: rdata_o shows, in the same cycle, the stored value of the register that addr_i selects. Any other address reads 0x00. Reading changes nothing.
- R12: A write to any address other than the five register addresses changes no register and no lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| special_i | input | 1 | 1 lifts the window and once-only rules for the current cycle |
| we_i | input | 1 | Write strobe |
| addr_i | input | 8 | Register address for both read and write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for addr_i |

## Verification
A write takes effect at the rising edge that samples it, so its result shows on rdata_o just after that edge. The read path has no register, so a value can be checked within the same cycle that addr_i is set. The window test depends on the exact number of edges since reset. For that reason the bench keeps its own count, and it updates the count in the same task that waits for each edge. It drives inputs on the falling edge and compares rdata_o a moment after it, always one edge after the write under test. The bench places the boundary writes on edge 63 and on edge 64 after release, to check where the window ends.

// File: rtl/cfg_guard_pkg.sv
// Shared constants and register descriptors for the guarded configuration bank.
// Assumes 8-bit registers; each descriptor splits a register's bits into
// free-write, once-only and set-only groups.
package cfg_guard_pkg;
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 8;
    localparam int NREG       = 5;
    localparam int WINDOW_CYC = 64;
    localparam int CNT_W      = $clog2(WINDOW_CYC + 1);

    localparam int IDX_TMR  = 0;
    localparam int IDX_PROT = 1;
    localparam int IDX_MAP  = 2;
    localparam int IDX_OPT  = 3;
    localparam int IDX_INIT = 4;

    typedef logic [DATA_W-1:0] byte_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        byte_t             free_m;   // bits written on every write
        byte_t             once_m;   // bits written only on a granted write
        byte_t             setc_m;   // bits set anytime, cleared only on a granted write
        byte_t             rst_v;    // reset value
        logic              windowed; // grant also needs the post-reset window
    } reg_desc_t;

    // Descriptor for register slot i.
    function automatic reg_desc_t reg_desc(int i);
        reg_desc_t d;
        d = '0;
        case (i)
            IDX_TMR:  begin d.addr = 8'h24; d.free_m = 8'hFC; d.once_m = 8'h03; d.windowed = 1'b1; end
            IDX_PROT: begin d.addr = 8'h35; d.setc_m = 8'hFF; d.rst_v  = 8'hFF; d.windowed = 1'b1; end
            IDX_MAP:  begin d.addr = 8'h37; d.once_m = 8'hF0; d.windowed = 1'b0; end
            IDX_OPT:  begin d.addr = 8'h39; d.free_m = 8'hC8; d.once_m = 8'h37; d.windowed = 1'b1; end
            default:  begin d.addr = 8'h3D; d.once_m = 8'hFF; d.windowed = 1'b1; end
        endcase
        return d;
    endfunction
endpackage

// File: rtl/cfg_window_timer.sv
// Post-reset window timer.
// Counts rising edges after reset release and stops at WINDOW; open_o is high
// while fewer than WINDOW edges have passed. Assumes synchronous active-low reset.
module cfg_window_timer #(
    parameter int WINDOW = cfg_guard_pkg::WINDOW_CYC,
    localparam int CW    = $clog2(WINDOW + 1)
) (
    input  logic clk,
    input  logic rst_n,
    output logic open_o
);
    logic [CW-1:0] cnt_q;

    // Saturating edge counter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_q != CW'(WINDOW))
            cnt_q <= cnt_q + 1'b1;
    end

    // Window is open until the counter reaches its limit.
    always_comb open_o = (cnt_q < CW'(WINDOW));
endmodule

// File: rtl/cfg_addr_decode.sv
// Address decoder: one hit line per register slot, from the descriptor table.
// Assumes register addresses are distinct.
module cfg_addr_decode #(
    parameter int NR = cfg_guard_pkg::NREG,
    parameter int AW = cfg_guard_pkg::ADDR_W
) (
    input  logic [AW-1:0] addr_i,
    output logic [NR-1:0] hit_o
);
    // One comparator per slot.
    for (genvar i = 0; i < NR; i++) begin : g_hit
        localparam cfg_guard_pkg::reg_desc_t D = cfg_guard_pkg::reg_desc(i);
        assign hit_o[i] = (addr_i == AW'(D.addr));
    end
endmodule

// File: rtl/cfg_field_reg.sv
// One guarded 8-bit register.
// Applies per-bit write rules from its descriptor: free bits always load,
// once bits load only on a granted write, set-only bits may clear only on a
// granted write. A grant needs special mode, or a clear lock plus (for
// windowed registers) an open window. Special-mode writes never set the lock.
module cfg_field_reg #(
    parameter cfg_guard_pkg::reg_desc_t DESC = cfg_guard_pkg::reg_desc(0)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  cfg_guard_pkg::byte_t wdata_i,
    input  logic                 win_open_i,
    input  logic                 special_i,
    output cfg_guard_pkg::byte_t q_o,
    output logic                 lock_o
);
    import cfg_guard_pkg::*;

    localparam byte_t IMPL_M  = DESC.free_m | DESC.once_m | DESC.setc_m;
    localparam bit    HAS_LIM = ((DESC.once_m | DESC.setc_m) != '0);

    byte_t q_q, q_nxt;
    logic  lock_q, lock_nxt, grant;

    // Decide whether limited bits may take this write.
    always_comb grant = special_i | (~lock_q & (win_open_i | ~DESC.windowed));

    // Compose the next stored value bit group by bit group.
    always_comb begin
        q_nxt    = q_q;
        lock_nxt = lock_q;
        if (wr_en_i) begin
            if (special_i) begin
                q_nxt = wdata_i & IMPL_M;
            end else begin
                q_nxt = (q_q & ~IMPL_M)
                      | (wdata_i & DESC.free_m)
                      | ((grant ? wdata_i : q_q) & DESC.once_m)
                      | ((grant ? wdata_i : (q_q | wdata_i)) & DESC.setc_m);
                if (grant && HAS_LIM)
                    lock_nxt = 1'b1;
            end
        end
    end

    // State update with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q    <= DESC.rst_v;
            lock_q <= 1'b0;
        end else begin
            q_q    <= q_nxt;
            lock_q <= lock_nxt;
        end
    end

    assign q_o    = q_q;
    assign lock_o = lock_q;
endmodule

// File: rtl/cfg_guard_bank.sv
// Guarded configuration register bank (top).
// Five 8-bit registers with per-bit write policies, a post-reset write window,
// per-register once-only locks and a special-mode bypass sampled every cycle.
// Reads are combinational; unmapped reads return zero.
module cfg_guard_bank #(
    parameter int AW = cfg_guard_pkg::ADDR_W,
    parameter int DW = cfg_guard_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          special_i,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o
);
    import cfg_guard_pkg::*;

    logic                      win_open;
    logic [NREG-1:0]           hit;
    logic [NREG-1:0]           lock_q;
    logic [NREG-1:0][DW-1:0]   reg_q;

    cfg_window_timer #(.WINDOW(WINDOW_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .open_o (win_open)
    );

    cfg_addr_decode #(.NR(NREG), .AW(AW)) u_dec (
        .addr_i (addr_i),
        .hit_o  (hit)
    );

    // One guarded register per descriptor slot.
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        cfg_field_reg #(.DESC(reg_desc(i))) u_reg (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en_i    (we_i & hit[i]),
            .wdata_i    (byte_t'(wdata_i)),
            .win_open_i (win_open),
            .special_i  (special_i),
            .q_o        (reg_q[i]),
            .lock_o     (lock_q[i])
        );
    end

    // Read multiplexer: OR of the selected register.
    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NREG; i++)
            if (hit[i])
                rdata_o = rdata_o | reg_q[i];
    end
endmodule

// File: rtl/cfg_guard_bank_chk.sv
// Checker for cfg_guard_bank: temporal rules on window, locks and protected bits.
module cfg_guard_bank_chk (
    input logic                                                   clk,
    input logic                                                   rst_n,
    input logic                                                   special_i,
    input logic                                                   we_i,
    input logic [7:0]                                             addr_i,
    input logic [7:0]                                             wdata_i,
    input logic                                                   win_open,
    input logic [cfg_guard_pkg::NREG-1:0]                         lock_q,
    input logic [cfg_guard_pkg::NREG-1:0][cfg_guard_pkg::DATA_W-1:0] reg_q
);
    import cfg_guard_pkg::*;

    // R2: once shut, the window stays shut until reset.
    a_r2_window_stays_shut: assert property (@(posedge clk) disable iff (!rst_n)
        !win_open |=> !win_open);

    // R8: a lock never falls without reset.
    a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((lock_q & $past(lock_q)) == $past(lock_q)));

    // R4: outside a grant the protection register never loses a set bit.
    a_r4_prot_no_late_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!special_i && (!win_open || lock_q[IDX_PROT])) |=>
        ((~reg_q[IDX_PROT] & $past(reg_q[IDX_PROT])) == '0));

    // R7: a locked init register holds in normal mode.
    a_r7_init_locked_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!special_i && lock_q[IDX_INIT]) |=> $stable(reg_q[IDX_INIT]));

    // R3: free bits of the timer register follow every write.
    a_r3_tmr_free_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == 8'h24) |=> (reg_q[IDX_TMR][7:2] == $past(wdata_i[7:2])));

    // R9: special-mode writes set no lock.
    a_r9_special_no_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (special_i && lock_q == '0) |=> (lock_q == '0));
endmodule

bind cfg_guard_bank cfg_guard_bank_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .special_i (special_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .win_open  (win_open),
    .lock_q    (lock_q),
    .reg_q     (reg_q)
);

// File: tb/cfg_guard_bank_test.sv
`timescale 1ns/1ps
module cfg_guard_bank_test;
    localparam real CLK_P = 8.0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       special = 1'b0;
    logic       we = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    cfg_guard_bank uut (
        .clk(clk), .rst_n(rst_n), .special_i(special), .we_i(we),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
    );

    always #(CLK_P/2) clk = ~clk;

    // Bench model, built from the requirements.
    logic [7:0] ADDRS [5] = '{8'h24, 8'h35, 8'h37, 8'h39, 8'h3D};
    logic [7:0] FREE  [5] = '{8'hFC, 8'h00, 8'h00, 8'hC8, 8'h00};
    logic [7:0] ONCE  [5] = '{8'h03, 8'h00, 8'hF0, 8'h37, 8'hFF};
    logic [7:0] SETC  [5] = '{8'h00, 8'hFF, 8'h00, 8'h00, 8'h00};
    logic [7:0] RSTV  [5] = '{8'h00, 8'hFF, 8'h00, 8'h00, 8'h00};
    bit         WIN   [5] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
    logic [7:0] m_q  [5];
    bit         m_lk [5];
    int         mcnt;

    function automatic int idx_of(logic [7:0] a);
        for (int i = 0; i < 5; i++) if (ADDRS[i] == a) return i;
        return -1;
    endfunction

    function automatic logic [7:0] exp_read(logic [7:0] a);
        int i = idx_of(a);
        return (i < 0) ? 8'h00 : m_q[i];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 5; i++) begin m_q[i] = RSTV[i]; m_lk[i] = 1'b0; end
        mcnt = 0;
    endtask

    // One clock cycle: drive at the falling edge, update the model, end at the next falling edge.
    task automatic cyc(bit w, logic [7:0] a, logic [7:0] d, bit sp);
        int i;
        bit g;
        logic [7:0] impl;
        we = w; addr = a; wdata = d; special = sp;
        i = idx_of(a);
        if (w && i >= 0) begin
            impl = FREE[i] | ONCE[i] | SETC[i];
            g = sp || (!m_lk[i] && (mcnt < 64 || !WIN[i]));
            if (sp) m_q[i] = d & impl;
            else begin
                m_q[i] = (d & FREE[i]) | ((g ? d : m_q[i]) & ONCE[i])
                       | ((g ? d : (m_q[i] | d)) & SETC[i]);
                if (g) m_lk[i] = 1'b1;
            end
        end
        if (mcnt < 64) mcnt++;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_rd(logic [7:0] a, string tag);
        logic [7:0] e;
        we = 1'b0; addr = a; special = 1'b0;
        #1;
        e = exp_read(a);
        checks++;
        if (rdata !== e) begin
            errors++;
            $display("FAIL %s addr=%02h actual=%02h expected=%02h", tag, a, rdata, e);
        end
        cyc(1'b0, a, 8'h00, 1'b0);
    endtask

    task automatic chk_all(string tag);
        for (int i = 0; i < 5; i++) chk_rd(ADDRS[i], tag);
    endtask

    task automatic do_reset();
        we = 1'b0; special = 1'b0; rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        do_reset();

        // R1: reset values, R11: unmapped reads give zero.
        chk_all("R1");
        chk_rd(8'h30, "R11");

        // R3 and R8: first write of 0x24 in window locks bits [1:0].
        cyc(1, 8'h24, 8'h02, 0);
        chk_rd(8'h24, "R3");
        cyc(1, 8'h24, 8'h01, 0);
        chk_rd(8'h24, "R3");

        // R8, R7, R10: writing the reset value still locks.
        cyc(1, 8'h3D, 8'h00, 0);
        cyc(1, 8'h3D, 8'h5A, 0);
        chk_rd(8'h3D, "R8");

        // R4: exact first write, then set-only.
        cyc(1, 8'h35, 8'hF0, 0);
        chk_rd(8'h35, "R4");
        cyc(1, 8'h35, 8'h0F, 0);
        chk_rd(8'h35, "R4");
        cyc(1, 8'h35, 8'h00, 0);
        chk_rd(8'h35, "R10");

        // R12: unmapped write changes nothing.
        cyc(1, 8'h30, 8'hAA, 0);
        chk_all("R12");
        chk_rd(8'h30, "R11");

        // Let the window close (R2).
        while (mcnt < 64) cyc(0, 8'h00, 8'h00, 0);
        cyc(1, 8'h39, 8'hFF, 0);
        chk_rd(8'h39, "R6");
        cyc(1, 8'h24, 8'hFF, 0);
        chk_rd(8'h24, "R3");

        // R5: map register once, no time limit; low nibble reads zero.
        cyc(1, 8'h37, 8'h5F, 0);
        chk_rd(8'h37, "R5");
        cyc(1, 8'h37, 8'hA0, 0);
        chk_rd(8'h37, "R5");

        // R9: special mode overrides locks and window, sampled per cycle.
        cyc(1, 8'h3D, 8'h33, 1);
        chk_rd(8'h3D, "R9");
        cyc(1, 8'h35, 8'h00, 1);
        chk_rd(8'h35, "R9");
        cyc(1, 8'h35, 8'h00, 0);
        cyc(1, 8'h35, 8'h81, 0);
        chk_rd(8'h35, "R4");
        cyc(1, 8'h39, 8'h00, 1);
        chk_rd(8'h39, "R9");

        // R2: last edge inside the window.
        do_reset();
        while (mcnt < 63) cyc(0, 8'h00, 8'h00, 0);
        cyc(1, 8'h3D, 8'h81, 0);
        chk_rd(8'h3D, "R2");

        // R2: first edge outside the window.
        do_reset();
        while (mcnt < 64) cyc(0, 8'h00, 8'h00, 0);
        cyc(1, 8'h3D, 8'h81, 0);
        chk_rd(8'h3D, "R2");
        cyc(1, 8'h35, 8'h00, 0);
        chk_rd(8'h35, "R4");

        // R9: special writes in window leave the lock clear.
        do_reset();
        cyc(1, 8'h3D, 8'h11, 1);
        cyc(1, 8'h3D, 8'h22, 0);
        chk_rd(8'h3D, "R9");
        cyc(1, 8'h3D, 8'h44, 0);
        chk_rd(8'h3D, "R7");

        // Random mix against the model (R10 and all rules).
        do_reset();
        for (int n = 0; n < 400; n++) begin
            int r = $urandom % 7;
            logic [7:0] a = (r < 5) ? ADDRS[r] : 8'($urandom);
            cyc(1, a, 8'($urandom), ($urandom % 8) == 0);
            chk_rd(ADDRS[$urandom % 5], "R10");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog.
    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule